// File: doc/BRIEF.md
# Burst-Mode DMA Channel Sequencer

This block moves data between two regions of external memory on behalf of several DMA channels. Every transfer unit is dual-address: the sequencer reads one byte or one word from the source address, keeps it in an internal holding register, and writes it to the destination address on the next bus access. Every bus access lasts two clock states. After each unit both addresses step by the unit size and the channel's count drops by one.

Each channel has its own register set: source address, destination address, count, a control word and a status word. A channel in burst mode keeps the bus once it has started. It runs unit after unit with no gap until its count is exhausted, and channels of higher priority wait meanwhile. A channel in single mode performs one unit per grant and then returns the bus. A rising edge on the NMI input disables every enabled burst channel and records an abort flag. An active burst stops at the next unit boundary, but a unit that has already begun always finishes. An optional end strobe marks the write of the final unit.

Top module: `dmaseq_top`

## Requirements
- R1: After reset all channel registers read zero, no bus strobe is active, the end strobe is low, and the address and write data buses are zero.
- R2: A unit is a read lasting two cycles followed immediately by a write lasting two cycles. The address is held for both cycles of each access, and the write carries the data read from the source address.
- R3: Control bit 1 selects the unit size. A word unit (1) asserts both write strobes, writes all 16 data bits and steps both addresses by 2. A byte unit (0) asserts only the low write strobe, writes the low read byte with the upper byte zero and steps both addresses by 1. The count decrements by 1 per unit.
- R4: With control bit 2 set (burst), the channel's units run back to back: the next read starts in the cycle after the second write state, so write accesses begin 4 cycles apart.
- R5: With control bit 2 clear (single), a channel performs one unit per grant and the bus returns to idle for one cycle, so consecutive writes of a channel whose request is held begin 5 cycles apart.
- R6: While a burst runs, requests from all other channels wait, including channels with a lower index. They are served only after the burst ends.
- R7: Grants are made only when the bus is idle. Among channels with the request high, control bit 0 (enable) set and a nonzero count, the lowest channel index wins.
- R8: With control bit 3 set, the end strobe is high during both write states of the unit that brings the count to zero, and it is never high otherwise. When the count reaches zero, enable clears.
- R9: A rising edge on nmi clears enable and sets the abort flag (status bit 1) of every channel that has both enable and burst set. Single-mode channels are unaffected. Status bit 0 mirrors enable.
- R10: When enable of the active burst channel is cleared, the unit in progress completes and the bus then returns to idle. The count keeps the number of units not transferred.
- R11: If the last unit of a burst has already begun when enable is cleared, that unit completes with its end strobe and the count reaches zero.
- R12: Writing the status register (select 4) with bit 1 set clears the abort flag. A channel whose count is zero is never granted. Register selects: 0 source, 1 destination, 2 count, 3 control, 4 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq | input | NCH | Level transfer request, one bit per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel addressed by register access |
| cfg_sel | input | 3 | Register select within the channel |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data, combinational |
| nmi | input | 1 | Non-maskable abort request, rising-edge detected |
| bus_addr | output | AW | External bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr_hi | output | 1 | High-byte write strobe |
| bus_wr_lo | output | 1 | Low-byte write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled in the second read state |
| bus_tend | output | 1 | Transfer-end strobe |

## Verification
The bench looks at the gap between writes. A design that paused between burst units, or that never idled between single-mode units, would put its writes at the wrong spacing. It raises a request on a lower-index channel in the middle of a burst to catch a design that re-arbitrates at unit boundaries. NMI is raised both in the first unit of a long burst and inside the last unit of a short one. A design that cut the unit in progress, kept running after the abort, or dropped the end strobe of the final unit would show a wrong write count, count residue or strobe. It also covers a zero-count channel with its request held, single-mode immunity to NMI, and byte-lane handling. A wrong lane would show as a stray high strobe or a nonzero upper byte.

// File: rtl/dmaseq_pkg.sv
// Shared types and constants for the DMA channel sequencer.
// Assumes register selects and control bit positions are fixed across channels.
package dmaseq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RD1  = 3'd1,
        PH_RD2  = 3'd2,
        PH_WR1  = 3'd3,
        PH_WR2  = 3'd4
    } phase_t;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_WORD  = 1;
    localparam int CTRL_BURST = 2;
    localparam int CTRL_TEND  = 3;
    localparam int STAT_ABORT = 1;
endpackage

// File: rtl/dmaseq_chregs.sv
// One channel's register set: addresses, count, control bits and abort flag.
// Assumes CW <= AW. Update order per cycle: unit completion, then NMI, then software write.
module dmaseq_chregs
    import dmaseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          unit_done,
    input  logic          nmi_rise,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic          en,
    output logic          word,
    output logic          burst,
    output logic          tend_en,
    output logic          abort
);
    logic [AW-1:0] step;

    // Address step follows the unit size.
    assign step = word ? AW'(2) : AW'(1);

    // Register state: hardware progress, NMI abort, then software access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src     <= '0;
            dst     <= '0;
            cnt     <= '0;
            en      <= 1'b0;
            word    <= 1'b0;
            burst   <= 1'b0;
            tend_en <= 1'b0;
            abort   <= 1'b0;
        end else begin
            if (unit_done) begin
                src <= src + step;
                dst <= dst + step;
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) en <= 1'b0;
            end
            if (nmi_rise && en && burst) begin
                en    <= 1'b0;
                abort <= 1'b1;
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_SRC:  src <= wr_data;
                    SEL_DST:  dst <= wr_data;
                    SEL_CNT:  cnt <= wr_data[CW-1:0];
                    SEL_CTRL: begin
                        en      <= wr_data[CTRL_EN];
                        word    <= wr_data[CTRL_WORD];
                        burst   <= wr_data[CTRL_BURST];
                        tend_en <= wr_data[CTRL_TEND];
                    end
                    SEL_STAT: if (wr_data[STAT_ABORT]) abort <= 1'b0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmaseq_arbiter.sv
// Fixed-priority pick among candidate channels, lowest index first.
// Assumes the caller only acts on the result while the bus is idle.
module dmaseq_arbiter #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] cand,
    output logic           any,
    output logic [CHW-1:0] idx
);
    // Scan from highest to lowest so the lowest index wins.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) idx = CHW'(i);
        end
        any = |cand;
    end
endmodule

// File: rtl/dmaseq_engine.sv
// Bus phase sequencer: two-state read, two-state write, burst looping.
// Assumes the selected channel's fields (c_*) are those of cur_idx.
module dmaseq_engine
    import dmaseq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           grant_any,
    input  logic [CHW-1:0] grant_idx,
    input  logic [AW-1:0]  c_src,
    input  logic [AW-1:0]  c_dst,
    input  logic [CW-1:0]  c_cnt,
    input  logic           c_en,
    input  logic           c_word,
    input  logic           c_burst,
    input  logic           c_tend_en,
    input  logic [DW-1:0]  bus_rdata,
    output logic [CHW-1:0] cur_idx,
    output logic           unit_done,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_rd,
    output logic           bus_wr_hi,
    output logic           bus_wr_lo,
    output logic [DW-1:0]  bus_wdata,
    output logic           bus_tend
);
    phase_t        ph;
    logic [DW-1:0] hold;
    logic          in_wr;
    logic          last_unit;

    // Phase progression, channel capture and read data holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            cur_idx <= '0;
            hold    <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (grant_any) begin
                    cur_idx <= grant_idx;
                    ph      <= PH_RD1;
                end
                PH_RD1: ph <= PH_RD2;
                PH_RD2: begin
                    hold <= c_word ? bus_rdata : DW'(bus_rdata[7:0]);
                    ph   <= PH_WR1;
                end
                PH_WR1: ph <= PH_WR2;
                PH_WR2: ph <= (c_burst && c_en && !last_unit) ? PH_RD1 : PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Bus outputs decoded from the current phase.
    always_comb begin
        last_unit = (c_cnt == CW'(1));
        in_wr     = (ph == PH_WR1) || (ph == PH_WR2);
        bus_rd    = (ph == PH_RD1) || (ph == PH_RD2);
        bus_wr_lo = in_wr;
        bus_wr_hi = in_wr && c_word;
        bus_addr  = bus_rd ? c_src : (in_wr ? c_dst : '0);
        bus_wdata = in_wr ? hold : '0;
        bus_tend  = in_wr && c_tend_en && last_unit;
        unit_done = (ph == PH_WR2);
    end
endmodule

// File: rtl/dmaseq_top.sv
// Multi-channel burst DMA sequencer top: channel registers, arbiter, engine, NMI edge.
// Assumes NCH >= 2 and CW <= AW; nmi is synchronous to clk.
module dmaseq_top
    import dmaseq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dreq,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [2:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    output logic [AW-1:0]  cfg_rdata,
    input  logic           nmi,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_rd,
    output logic           bus_wr_hi,
    output logic           bus_wr_lo,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic           bus_tend
);
    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    logic [NCH-1:0] en_v, word_v, burst_v, tend_v, abort_v, cand;
    logic           nmi_s, nmi_q, nmi_rise;
    logic           grant_any, unit_done;
    logic [CHW-1:0] grant_idx, cur_idx;

    // NMI sampled once per clock; rising edge found against the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_s <= 1'b0;
            nmi_q <= 1'b0;
        end else begin
            nmi_s <= nmi;
            nmi_q <= nmi_s;
        end
    end
    assign nmi_rise = nmi_s && !nmi_q;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            dmaseq_chregs #(.AW(AW), .CW(CW)) u_regs (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (cfg_we && (cfg_ch == CHW'(g))),
                .wr_sel    (cfg_sel),
                .wr_data   (cfg_wdata),
                .unit_done (unit_done && (cur_idx == CHW'(g))),
                .nmi_rise  (nmi_rise),
                .src       (src_a[g]),
                .dst       (dst_a[g]),
                .cnt       (cnt_a[g]),
                .en        (en_v[g]),
                .word      (word_v[g]),
                .burst     (burst_v[g]),
                .tend_en   (tend_v[g]),
                .abort     (abort_v[g])
            );
            assign cand[g] = dreq[g] && en_v[g] && (cnt_a[g] != '0);
        end
    endgenerate

    dmaseq_arbiter #(.NCH(NCH)) u_arb (
        .cand (cand),
        .any  (grant_any),
        .idx  (grant_idx)
    );

    dmaseq_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_any (grant_any),
        .grant_idx (grant_idx),
        .c_src     (src_a[cur_idx]),
        .c_dst     (dst_a[cur_idx]),
        .c_cnt     (cnt_a[cur_idx]),
        .c_en      (en_v[cur_idx]),
        .c_word    (word_v[cur_idx]),
        .c_burst   (burst_v[cur_idx]),
        .c_tend_en (tend_v[cur_idx]),
        .bus_rdata (bus_rdata),
        .cur_idx   (cur_idx),
        .unit_done (unit_done),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr_hi (bus_wr_hi),
        .bus_wr_lo (bus_wr_lo),
        .bus_wdata (bus_wdata),
        .bus_tend  (bus_tend)
    );

    // Register read mux for the addressed channel.
    always_comb begin
        case (cfg_sel)
            SEL_SRC:  cfg_rdata = src_a[cfg_ch];
            SEL_DST:  cfg_rdata = dst_a[cfg_ch];
            SEL_CNT:  cfg_rdata = AW'(cnt_a[cfg_ch]);
            SEL_CTRL: cfg_rdata = AW'({tend_v[cfg_ch], burst_v[cfg_ch],
                                       word_v[cfg_ch], en_v[cfg_ch]});
            SEL_STAT: cfg_rdata = AW'({abort_v[cfg_ch], en_v[cfg_ch]});
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmaseq_checker.sv
// Bus protocol properties of the sequencer, bound to every dmaseq_top instance.
// Assumes only the top-level bus ports are visible.
module dmaseq_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr_hi,
    input logic          bus_wr_lo,
    input logic          bus_tend
);
    a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && (bus_wr_lo || bus_wr_hi)));

    a_r2_read_two_states: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |=> (bus_rd && $stable(bus_addr)));

    a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd) |-> bus_wr_lo);

    a_r2_write_two_states: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_lo) |=> (bus_wr_lo && $stable(bus_addr)));

    a_r3_hi_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_hi |-> bus_wr_lo);

    a_r8_tend_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tend |-> bus_wr_lo);
endmodule

bind dmaseq_top dmaseq_checker #(.AW(AW)) u_dmaseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr_hi (bus_wr_hi),
    .bus_wr_lo (bus_wr_lo),
    .bus_tend  (bus_tend)
);

// File: tb/dmaseq_top_bench.sv
// Scoreboard bench: driver tasks queue expected write accesses, a monitor compares them.
module dmaseq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int CW  = 8;
    localparam int WD_CYCLES = 20000;

    localparam logic [AW-1:0] C_EN = 16'd1, C_WORD = 16'd2, C_BURST = 16'd4, C_TEND = 16'd8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] dreq = '0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [2:0]     cfg_sel = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [AW-1:0]  cfg_rdata;
    logic           nmi = 1'b0;
    logic [AW-1:0]  bus_addr;
    logic           bus_rd, bus_wr_hi, bus_wr_lo, bus_tend;
    logic [DW-1:0]  bus_wdata, bus_rdata;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          hi;
        logic          tend;
        int            gap;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    int    last_start = 0;
    int    nwrites = 0;
    logic  prev_wr = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
        return a ^ 16'h5A3C;
    endfunction

    // External memory model: read data is a fixed function of the address.
    assign bus_rdata = bus_rd ? mem(bus_addr) : '0;

    dmaseq_top #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_dmaseq_top (
        .clk (clk), .rst_n (rst_n), .dreq (dreq),
        .cfg_we (cfg_we), .cfg_ch (cfg_ch), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .nmi (nmi),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr_hi (bus_wr_hi),
        .bus_wr_lo (bus_wr_lo), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_tend (bus_tend)
    );

    function automatic void chk(input string rq, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endfunction

    // Monitor: every new write access is compared with the head of the queue.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && bus_wr_lo && !prev_wr) begin
            nwrites++;
            if (exp_q.size() == 0) begin
                chk("R6/R10/R12", "unexpected write addr", {16'h0, bus_addr}, 32'hFFFF_FFFF);
            end else begin
                item_t it;
                string tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(tg, "write addr", bus_addr, it.addr);
                chk(tg, "write data", bus_wdata, it.data);
                chk(tg, "high strobe", bus_wr_hi, it.hi);
                chk(tg, "end strobe", bus_tend, it.tend);
                if (it.gap >= 0) chk(tg, "write spacing", cyc - last_start, it.gap);
            end
            last_start = cyc;
        end
        prev_wr = bus_wr_lo;
    end

    task automatic reg_wr(input int ch, input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input int ch, input logic [2:0] sel, output logic [AW-1:0] d);
        @(negedge clk);
        cfg_ch = 2'(ch); cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic setup(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input logic [AW-1:0] n, input logic [AW-1:0] ctrl);
        reg_wr(ch, 3'd0, s);
        reg_wr(ch, 3'd1, d);
        reg_wr(ch, 3'd2, n);
        reg_wr(ch, 3'd3, ctrl);
    endtask

    // Driver: queue the writes a channel is expected to make.
    task automatic expect_units(input logic [AW-1:0] s, input logic [AW-1:0] d,
                                input int run, input int total, input bit word,
                                input bit burst, input bit tend_en, input string tg);
        for (int k = 0; k < run; k++) begin
            item_t it;
            logic [AW-1:0] sa, da, st;
            st = word ? 16'd2 : 16'd1;
            sa = s + AW'(k) * st;
            da = d + AW'(k) * st;
            it.addr = da;
            it.data = word ? mem(sa) : {8'h00, mem(sa)[7:0]};
            it.hi   = word;
            it.tend = tend_en && (k == total - 1);
            it.gap  = (k == 0) ? -1 : (burst ? 4 : 5);
            exp_q.push_back(it);
            tag_q.push_back(tg);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_write();
        @(negedge clk);
        while (!bus_wr_lo) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [AW-1:0] rd;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports and in the registers
        @(negedge clk);
        chk("R1", "bus strobes", {bus_rd, bus_wr_hi, bus_wr_lo, bus_tend}, 0);
        chk("R1", "bus addr", bus_addr, 0);
        chk("R1", "bus wdata", bus_wdata, 0);
        reg_rd(0, 3'd2, rd); chk("R1", "count", rd, 0);
        reg_rd(2, 3'd0, rd); chk("R1", "source", rd, 0);
        reg_rd(3, 3'd4, rd); chk("R1", "status", rd, 0);

        // R2/R3/R4/R8: word burst with end strobe
        setup(1, 16'h1000, 16'h2000, 16'd3, C_EN | C_WORD | C_BURST | C_TEND);
        expect_units(16'h1000, 16'h2000, 3, 3, 1, 1, 1, "R2/R3/R4/R8");
        dreq[1] = 1'b1;
        drain();
        dreq[1] = 1'b0;
        reg_rd(1, 3'd2, rd); chk("R3", "count after word burst", rd, 0);
        reg_rd(1, 3'd4, rd); chk("R8", "enable after completion", rd, 0);
        reg_rd(1, 3'd0, rd); chk("R3", "source stepped by 2", rd, 16'h1006);

        // R3/R4: byte burst, end strobe disabled
        setup(0, 16'h0301, 16'h0400, 16'd2, C_EN | C_BURST);
        expect_units(16'h0301, 16'h0400, 2, 2, 0, 1, 0, "R3/R4");
        dreq[0] = 1'b1;
        drain();
        dreq[0] = 1'b0;
        reg_rd(0, 3'd1, rd); chk("R3", "destination stepped by 1", rd, 16'h0402);

        // R5/R8: single mode with request held, idle cycle between units
        setup(2, 16'h0500, 16'h0600, 16'd2, C_EN | C_WORD | C_TEND);
        expect_units(16'h0500, 16'h0600, 2, 2, 1, 0, 1, "R5/R8");
        dreq[2] = 1'b1;
        drain();
        dreq[2] = 1'b0;
        reg_rd(2, 3'd4, rd); chk("R5", "single channel finished", rd, 0);

        // R6: lower-index request during a burst waits for the burst to end
        setup(1, 16'h1100, 16'h2100, 16'd4, C_EN | C_WORD | C_BURST);
        setup(0, 16'h3000, 16'h3100, 16'd1, C_EN | C_WORD);
        expect_units(16'h1100, 16'h2100, 4, 4, 1, 1, 0, "R6");
        expect_units(16'h3000, 16'h3100, 1, 1, 1, 0, 0, "R6");
        dreq[1] = 1'b1;
        wait_write();
        dreq[0] = 1'b1;
        drain();
        dreq = '0;

        // R7: simultaneous requests at idle, lowest index first
        setup(3, 16'h4000, 16'h4100, 16'd1, C_EN | C_WORD);
        setup(1, 16'h5000, 16'h5100, 16'd1, C_EN | C_WORD);
        expect_units(16'h5000, 16'h5100, 1, 1, 1, 0, 0, "R7");
        expect_units(16'h4000, 16'h4100, 1, 1, 1, 0, 0, "R7");
        @(negedge clk);
        dreq[1] = 1'b1; dreq[3] = 1'b1;
        drain();
        dreq = '0;

        // R9/R10: NMI during the first unit of a long burst; two units run
        setup(1, 16'h6000, 16'h7000, 16'd5, C_EN | C_WORD | C_BURST | C_TEND);
        expect_units(16'h6000, 16'h7000, 2, 5, 1, 1, 1, "R10");
        dreq[1] = 1'b1;
        wait_write();
        nmi = 1'b1;
        drain();
        repeat (10) @(negedge clk);
        chk("R10", "queue empty after abort", exp_q.size(), 0);
        reg_rd(1, 3'd2, rd); chk("R10", "count residue", rd, 3);
        reg_rd(1, 3'd4, rd); chk("R9", "status after abort", rd, 16'h2);
        dreq[1] = 1'b0;
        nmi = 1'b0;

        // R11: NMI lands inside the final unit; it completes with end strobe
        setup(0, 16'h0800, 16'h0900, 16'd2, C_EN | C_WORD | C_BURST | C_TEND);
        expect_units(16'h0800, 16'h0900, 2, 2, 1, 1, 1, "R11");
        dreq[0] = 1'b1;
        wait_write();
        repeat (2) @(negedge clk);
        nmi = 1'b1;
        drain();
        dreq[0] = 1'b0;
        nmi = 1'b0;
        reg_rd(0, 3'd2, rd); chk("R11", "count reached zero", rd, 0);
        reg_rd(0, 3'd4, rd); chk("R11", "status after late NMI", rd, 16'h2);

        // R9: single-mode channel ignores NMI
        setup(2, 16'h0A00, 16'h0B00, 16'd3, C_EN | C_WORD);
        nmi = 1'b1;
        repeat (4) @(negedge clk);
        nmi = 1'b0;
        reg_rd(2, 3'd4, rd); chk("R9", "single channel unaffected", rd, 16'h1);
        reg_wr(2, 3'd3, 16'h0);

        // R12: abort flag cleared by status write
        reg_wr(1, 3'd4, 16'h2);
        reg_rd(1, 3'd4, rd); chk("R12", "abort cleared", rd, 0);

        // R12: zero count never granted
        setup(3, 16'h0C00, 16'h0D00, 16'd0, C_EN | C_BURST | C_WORD);
        base = nwrites;
        dreq[3] = 1'b1;
        repeat (20) @(negedge clk);
        dreq[3] = 1'b0;
        chk("R12", "writes from zero-count channel", nwrites - base, 0);
        reg_rd(3, 3'd4, rd); chk("R12", "zero-count channel status", rd, 16'h1);

        finish_run();
    end
endmodule